// File: doc/BRIEF.md
# Reset Glitch Filter

This block cleans up a raw, active-high reset line that is already sampled in the local clock domain. A short spike on the raw line must not reset the logic downstream. The filtered reset therefore asserts only after the raw line has stayed high for `PERIOD` clock edges in a row. Once it is asserted, it follows the raw line's high run and releases shortly after that run ends. The output comes from a register, so no combinational path runs from the raw input to the filtered reset.

A separate synchronous system reset marks power-up. For the first `PERIOD` cycles after that reset is released, the filtered output is held asserted whatever the raw line does. If the raw line is already high and qualifies before that window closes, the output stays asserted with no gap. `PERIOD` is a parameter and must be at least 1.

Top module: `reset_glitch_filter`

## Requirements
- R1: After the start-up window, `filt_rst_o` goes from 0 to 1 only in the cycle after the edge at which `raw_rst_i` was sampled high for the `PERIOD`-th consecutive time.
- R2: Once asserted, `filt_rst_o` stays 1 in cycle t+1 whenever `raw_rst_i` was sampled high at the edge ending cycle t-1. The output drops two cycles after the first low sample of the raw line.
- R3: After `rst_i` is released, `filt_rst_o` reads 1 in each of the first `PERIOD` cycles (cycle 0 to cycle `PERIOD`-1), whatever `raw_rst_i` does.
- R4: While `rst_i` is sampled high, `filt_rst_o` reads 1 in the following cycle. `rst_i` is synchronous and active high.
- R5: After the start-up window, a high run on `raw_rst_i` shorter than `PERIOD` samples leaves `filt_rst_o` at 0. A single low sample resets the consecutive count to zero.
- R6: With `PERIOD`=2, a raw sequence of 1,1,0,0,1,0,0,1,1,0,1,0 starting at release gives the output 1,1,1,1,0,0,0,0,0,1,1,0 in cycles 0 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high system reset (start of the power-up window) |
| raw_rst_i | input | 1 | Raw active-high reset, already sampled in this domain |
| filt_rst_o | output | 1 | Filtered active-high reset, registered |

## Verification
The assertions check several rules on every cycle:
- the run counter climbs by one on each high sample and clears on each low sample;
- the output cannot rise without a full run or the start-up window;
- an asserted output is held while the previous sample was high;
- the output is high during the window and after reset.

Only the bench's scenarios can show the exact cycle in which the output falls after a run ends, and that isolated pulses and runs one short of `PERIOD` stay invisible. The same applies to the documented twelve-cycle trace and to a start-up window that runs straight into a qualifying run. The bench drives three instances with `PERIOD` of 1, 2 and 5 from a shared stream.

// File: rtl/rgf_pkg.sv
package rgf_pkg;

    // Phase of the start-up window
    typedef enum logic {
        PH_BOOT = 1'b0,
        PH_LIVE = 1'b1
    } phase_e;

    // Inputs to the next-level decision of the output register
    typedef struct packed {
        logic boot_next;  // next cycle still inside the start-up window
        logic run_hit;    // consecutive-high count reaches the period this edge
        logic prev_high;  // raw line was high on the previous edge
    } vote_t;

    function automatic logic next_level(vote_t v, logic cur);
        return v.boot_next | v.run_hit | (cur & v.prev_high);
    endfunction

endpackage

// File: rtl/rgf_run_counter.sv
module rgf_run_counter #(
    parameter int PERIOD = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic raw_i,
    output logic hit_o,
    output logic prev_high_o
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] SAT = CW'(PERIOD);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        if (!raw_i)
            cnt_d = '0;
        else if (cnt_q == SAT)
            cnt_d = SAT;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign hit_o       = (cnt_d == SAT);
    assign prev_high_o = (cnt_q != '0);

    // R5
    run_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !raw_i |=> (cnt_q == '0));

    // R1
    run_climb_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (raw_i && cnt_q != SAT) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/rgf_boot_window.sv
module rgf_boot_window #(
    parameter int PERIOD = 4
) (
    input  logic           clk_i,
    input  logic           rst_i,
    output logic           boot_next_o,
    output rgf_pkg::phase_e phase_o
);
    import rgf_pkg::*;

    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] SAT    = CW'(PERIOD);
    localparam logic [CW-1:0] SAT_M1 = CW'(PERIOD - 1);

    logic [CW-1:0] age_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            age_q <= '0;
        else if (age_q != SAT)
            age_q <= age_q + 1'b1;
    end

    // age_q equals the number of cycles since release, saturated at PERIOD
    assign boot_next_o = (age_q < SAT_M1);
    assign phase_o     = (age_q < SAT) ? PH_BOOT : PH_LIVE;

    // R3
    age_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        age_q <= SAT);

endmodule

// File: rtl/rgf_output_stage.sv
module rgf_output_stage (
    input  logic           clk_i,
    input  logic           rst_i,
    input  rgf_pkg::vote_t vote_i,
    output logic           level_o
);
    import rgf_pkg::*;

    logic level_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            level_q <= 1'b1;
        else
            level_q <= next_level(vote_i, level_q);
    end

    assign level_o = level_q;

endmodule

// File: rtl/reset_glitch_filter.sv
module reset_glitch_filter #(
    parameter int PERIOD = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic raw_rst_i,
    output logic filt_rst_o
);
    import rgf_pkg::*;

    logic   run_hit;
    logic   prev_high;
    logic   boot_next;
    phase_e phase;
    vote_t  vote;

    rgf_run_counter #(.PERIOD(PERIOD)) u_run (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .raw_i       (raw_rst_i),
        .hit_o       (run_hit),
        .prev_high_o (prev_high)
    );

    rgf_boot_window #(.PERIOD(PERIOD)) u_boot (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .boot_next_o (boot_next),
        .phase_o     (phase)
    );

    always_comb begin
        vote.boot_next = boot_next;
        vote.run_hit   = run_hit;
        vote.prev_high = prev_high;
    end

    rgf_output_stage u_out (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .vote_i  (vote),
        .level_o (filt_rst_o)
    );

    // R1
    no_early_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!filt_rst_o && !run_hit && !boot_next) |=> !filt_rst_o);

    // R2
    hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (filt_rst_o && prev_high) |=> filt_rst_o);

    // R3
    boot_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase == PH_BOOT) |-> filt_rst_o);

    // R4
    reset_high_chk: assert property (@(posedge clk_i)
        rst_i |=> filt_rst_o);

endmodule

// File: tb/reset_glitch_filter_tb.sv
module reset_glitch_filter_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NDUT = 3;
    localparam int  PV [NDUT] = '{1, 2, 5};
    localparam logic [11:0] TRACE_IN  = 12'b0101_1001_0011; // bit k = cycle k
    localparam logic [11:0] TRACE_OUT = 12'b0110_0000_1111;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic raw = 1'b0;
    logic [NDUT-1:0] got;

    int checks = 0;
    int fails  = 0;
    int t      = 0;
    bit in_h[$];
    bit prev_exp [NDUT];
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    reset_glitch_filter #(.PERIOD(1)) u_dut1 (.clk_i(clk), .rst_i(rst), .raw_rst_i(raw), .filt_rst_o(got[0]));
    reset_glitch_filter #(.PERIOD(2)) u_dut  (.clk_i(clk), .rst_i(rst), .raw_rst_i(raw), .filt_rst_o(got[1]));
    reset_glitch_filter #(.PERIOD(5)) u_dut5 (.clk_i(clk), .rst_i(rst), .raw_rst_i(raw), .filt_rst_o(got[2]));

    function automatic bit ref_level(int p, int tc, bit prev);
        bit all_high;
        if (tc < p) return 1'b1;
        all_high = 1'b1;
        for (int k = tc - p; k < tc; k++) all_high &= in_h[k];
        if (all_high) return 1'b1;
        if (tc >= 2 && prev && in_h[tc-2]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check_now();
        for (int d = 0; d < NDUT; d++) begin
            bit e;
            string tag;
            e = ref_level(PV[d], t, prev_exp[d]);
            if (t < PV[d])               tag = "R3";
            else if (e && prev_exp[d])   tag = "R2";
            else if (e)                  tag = "R1";
            else                         tag = "R5";
            checks++;
            if (got[d] !== e) begin
                fails++;
                $display("FAIL %s P=%0d cycle %0d: actual %b expected %b", tag, PV[d], t, got[d], e);
            end
            prev_exp[d] = e;
        end
    endtask

    // check the current cycle, drive the next raw sample, advance to the next negedge
    task automatic step(bit v);
        check_now();
        raw = v;
        in_h.push_back(v);
        t++;
        @(negedge clk);
    endtask

    task automatic do_reset(bit raw_during);
        rst = 1'b1;
        raw = raw_during;
        repeat (3) begin
            @(negedge clk);
            for (int d = 0; d < NDUT; d++) begin
                checks++;
                if (got[d] !== 1'b1) begin
                    fails++;
                    $display("FAIL R4 P=%0d in reset: actual %b expected 1", PV[d], got[d]);
                end
            end
        end
        rst = 1'b0;
        t = 0;
        in_h.delete();
    endtask

    initial begin
        do_reset(1'b0);
        // documented trace for PERIOD=2
        for (int k = 0; k < 12; k++) begin
            checks++;
            if (got[1] !== TRACE_OUT[k]) begin
                fails++;
                $display("FAIL R6 cycle %0d: actual %b expected %b", k, got[1], TRACE_OUT[k]);
            end
            step(TRACE_IN[k]);
        end
        // isolated one-cycle pulses
        for (int k = 0; k < 6; k++) begin step(1'b1); step(1'b0); step(1'b0); end
        // runs of growing length
        for (int len = 1; len <= 7; len++) begin
            for (int k = 0; k < len; k++) step(1'b1);
            for (int k = 0; k < 3; k++) step(1'b0);
        end
        // pseudo-random stream
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[3]);
        end
        // raw high through reset and beyond: window runs into a qualifying run
        do_reset(1'b1);
        for (int k = 0; k < 12; k++) step(1'b1);
        for (int k = 0; k < 8; k++) step(1'b0);
        // raw low at release with a run one short of the largest period
        do_reset(1'b0);
        for (int k = 0; k < 6; k++) step(1'b0);
        for (int k = 0; k < 4; k++) step(1'b1);
        for (int k = 0; k < 6; k++) step(1'b0);
        check_now();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule